// File: doc/BRIEF.md
# Branch Direction Predictor with Last-Outcome Table

This block predicts, at instruction fetch, whether a conditional branch is taken. The fetch stage presents the branch PC, the sign of its displacement and a request strobe. The predictor returns a registered taken/not-taken answer one clock later, so the pipeline can act on it and later compare it with the resolved outcome. When a branch resolves, the execute side drives the branch PC and its actual direction on a separate update port.

The predictor keeps a direct-mapped table addressed by a field of the PC just above the word-alignment bits. Branches whose PCs share that field share one entry. Each entry holds two bits: a trained flag and the direction the branch took last time. A trained entry predicts a repeat of the last outcome. An entry that has never been written since reset falls back to a static rule: a branch with a negative displacement (a loop back-edge) is predicted taken, and a forward branch is predicted not taken.

Top module: `bp_history_predictor`

## Requirements
- R1: While reset is high and in the first cycle after it, pred_vld_o is 0. Reset marks every table entry untrained.
- R2: The table index is pred_pc_i[IDX_W+1:2] (upd_pc_i[IDX_W+1:2] for updates). Two PCs that are equal in those bits read and write the same entry.
- R3: For a request to an untrained entry, pred_taken_o is 1 when pred_back_i is 1 (negative displacement) and 0 when pred_back_i is 0.
- R4: For a request to a trained entry, pred_taken_o equals the last outcome written to that entry, whatever the value of pred_back_i.
- R5: An update with upd_vld_i high sets the entry's trained flag and stores upd_taken_i in one clock. A request issued in the following cycle sees the new value.
- R6: When a request and an update address the same entry in the same cycle, the prediction uses the entry's value from before that update.
- R7: pred_vld_o equals pred_vld_i of the previous cycle. pred_taken_o is 0 whenever pred_vld_o is 0.
- R8: Values on upd_pc_i and upd_taken_i are ignored while upd_vld_i is 0.
- R9: Asserting reset in the middle of operation discards all training, so later requests follow the static rule again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_vld_i | input | 1 | Prediction request strobe |
| pred_pc_i | input | PC_W | PC of the branch to predict |
| pred_back_i | input | 1 | 1 when the branch displacement is negative |
| upd_vld_i | input | 1 | Resolution update strobe |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |
| pred_vld_o | output | 1 | Prediction valid, one cycle after the request |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |

## Verification
On every cycle, the assertions check the following: the quiet output after reset, the one-cycle latency of the valid strobe with the taken bit gated off when idle, the static answer for untrained entries, and that a write marks its entry trained on the next cycle. Other behaviours can only be shown by the bench's scenarios, because they depend on the history of one entry over many cycles. These are repeating the last outcome on loop-like and alternating streams, aliasing between PCs, the pre-update read on a same-entry collision, ignored updates, and loss of training on a mid-run reset.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  import bp_pkg::*;
  assign idx = pc[WORD_LSB +: IDX_W];
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_dir,
  output logic             rd_trained,
  output logic             rd_dir
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  // Trained flags live in flops so reset can clear them all at once.
  logic [DEPTH-1:0] trained_q;
  // Direction bits need no reset, so they can map onto a RAM.
  logic             dir_mem [DEPTH];
  logic             rd_trained_q;
  logic             rd_dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trained_q <= '0;
    end else if (wr_en) begin
      trained_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) dir_mem[wr_idx] <= wr_dir;
    if (rd_en) rd_dir_q <= dir_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_trained_q <= 1'b0;
    else if (rd_en) rd_trained_q <= trained_q[rd_idx];
  end

  assign rd_trained = rd_trained_q;
  assign rd_dir     = rd_dir_q;

  // R5: a write leaves its entry trained on the following cycle
  a_r5_write_trains: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> trained_q[$past(wr_idx)]);
endmodule

// File: rtl/bp_history_predictor.sv
module bp_history_predictor #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_vld_i,
  input  logic [PC_W-1:0] pred_pc_i,
  input  logic            pred_back_i,
  input  logic            upd_vld_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  output logic            pred_vld_o,
  output logic            pred_taken_o
);
  import bp_pkg::*;

  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             ent_trained;
  logic             ent_dir;
  logic             vld_q;
  logic             back_q;
  dir_e             static_dir;
  dir_e             final_dir;

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) i_rd_index (.pc(pred_pc_i), .idx(rd_idx));
  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) i_wr_index (.pc(upd_pc_i),  .idx(wr_idx));

  bp_hist_table #(.IDX_W(IDX_W)) i_table (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (pred_vld_i),
    .rd_idx     (rd_idx),
    .wr_en      (upd_vld_i),
    .wr_idx     (wr_idx),
    .wr_dir     (upd_taken_i),
    .rd_trained (ent_trained),
    .rd_dir     (ent_dir)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      back_q <= 1'b0;
    end else begin
      vld_q <= pred_vld_i;
      if (pred_vld_i) back_q <= pred_back_i;
    end
  end

  always_comb begin
    static_dir = back_q ? DIR_TAKEN : DIR_NOT_TAKEN;
    final_dir  = ent_trained ? dir_e'(ent_dir) : static_dir;
  end

  assign pred_vld_o   = vld_q;
  assign pred_taken_o = vld_q & (final_dir == DIR_TAKEN);

  // R1: nothing is reported in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_vld_o);

  // R7: valid follows the request by one cycle
  a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pred_vld_o == $past(pred_vld_i)));

  // R7: taken bit is low while idle
  a_r7_idle_not_taken: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pred_vld_i)) |-> !pred_taken_o);

  // R3: untrained entries follow the displacement sign
  a_r3_static_rule: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pred_vld_i) && !ent_trained) |-> (pred_taken_o == $past(pred_back_i)));
endmodule

// File: tb/test_bp_history_predictor.sv
module test_bp_history_predictor;
  localparam int PC_W  = 32;
  localparam int IDX_W = 6;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pred_vld_i = 1'b0, pred_back_i = 1'b0;
  logic upd_vld_i = 1'b0, upd_taken_i = 1'b0;
  logic [PC_W-1:0] pred_pc_i = '0, upd_pc_i = '0;
  logic pred_vld_o, pred_taken_o;

  bp_history_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) i_bp_history_predictor (
    .clk(clk), .rst(rst), .pred_vld_i(pred_vld_i), .pred_pc_i(pred_pc_i),
    .pred_back_i(pred_back_i), .upd_vld_i(upd_vld_i), .upd_pc_i(upd_pc_i),
    .upd_taken_i(upd_taken_i), .pred_vld_o(pred_vld_o), .pred_taken_o(pred_taken_o));

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic ref_trained [DEPTH];
  logic ref_dir     [DEPTH];
  logic pend = 1'b0, exp_v = 1'b0, exp_t = 1'b0;
  string pend_tag = "";

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic model_pred(input logic [PC_W-1:0] pc, input logic back);
    int i = idx_of(pc);
    return ref_trained[i] ? ref_dir[i] : back;
  endfunction

  task automatic check(input string tag, input logic act_v, input logic act_t,
                       input logic e_v, input logic e_t);
    checks++;
    if (act_v !== e_v || act_t !== e_t) begin
      fails++;
      $display("FAIL %s: vld/taken actual %0b/%0b expected %0b/%0b", tag, act_v, act_t, e_v, e_t);
    end
  endtask

  // One cycle: check the previous request's answer, then drive new inputs.
  task automatic cyc(input logic pv, input logic [PC_W-1:0] ppc, input logic pb,
                     input logic uv, input logic [PC_W-1:0] upc, input logic ut,
                     input string tag);
    @(negedge clk);
    if (pend) check(pend_tag, pred_vld_o, pred_taken_o, exp_v, exp_t);
    pred_vld_i = pv; pred_pc_i = ppc; pred_back_i = pb;
    upd_vld_i = uv; upd_pc_i = upc; upd_taken_i = ut;
    exp_v = pv;
    exp_t = pv & model_pred(ppc, pb);   // R6: computed before the update lands
    pend = 1'b1; pend_tag = tag;
    if (uv) begin
      ref_trained[idx_of(upc)] = 1'b1;
      ref_dir[idx_of(upc)]     = ut;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pred_vld_i = 1'b0; upd_vld_i = 1'b0;
    pend = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin ref_trained[i] = 1'b0; ref_dir[i] = 1'b0; end
    @(negedge clk);
    check("R1 during reset", pred_vld_o, pred_taken_o, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", pred_vld_o, pred_taken_o, 1'b0, 1'b0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    do_reset();

    // R3: fresh entries use the static rule
    cyc(1, 32'h0000_0010, 1, 0, 0, 0, "R3 untrained backward");
    cyc(1, 32'h0000_0014, 0, 0, 0, 0, "R3 untrained forward");
    // R7: idle cycle
    cyc(0, 32'h0000_0010, 1, 0, 0, 0, "R7 idle");
    // R5/R4: train then read with the opposite sign
    cyc(0, 0, 0, 1, 32'h0000_0020, 1, "R5 write");
    cyc(1, 32'h0000_0020, 0, 0, 0, 0, "R4 trained taken forward");
    cyc(0, 0, 0, 1, 32'h0000_0024, 0, "R5 write");
    cyc(1, 32'h0000_0024, 1, 0, 0, 0, "R4 trained not-taken backward");
    // R2: aliasing PCs share an entry
    cyc(0, 0, 0, 1, 32'h0000_0100, 1, "R2 write");
    cyc(1, 32'h0000_0200, 0, 0, 0, 0, "R2 alias reads trained entry");
    cyc(1, 32'h0000_0104, 0, 0, 0, 0, "R2 neighbour untrained");
    // R6: same-entry collision sees old value, then R5 next cycle
    cyc(1, 32'h0000_0040, 0, 1, 32'h0000_0040, 1, "R6 collision pre-update");
    cyc(1, 32'h0000_0040, 0, 0, 0, 0, "R5 visible next cycle");
    cyc(1, 32'h0000_0040, 1, 1, 32'h0000_0040, 0, "R6 collision trained");
    cyc(1, 32'h0000_0040, 1, 0, 0, 0, "R5 overwrite visible");
    // R8: ignored update
    cyc(0, 0, 0, 0, 32'h0000_0080, 1, "R8 strobe low");
    cyc(1, 32'h0000_0080, 0, 0, 32'h0000_0040, 1, "R8 untrained stays static");
    cyc(1, 32'h0000_0040, 0, 0, 0, 0, "R8 trained value kept");

    // Loop-like and alternating streams with random interleaving
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 3);
      logic [PC_W-1:0] lpc = 32'h0000_1000 + 32'(4 * $urandom_range(0, 7));
      logic [PC_W-1:0] apc = 32'h0000_2000 + 32'(4 * $urandom_range(0, 7));
      logic [PC_W-1:0] ppc = sel[0] ? lpc : apc;
      logic [PC_W-1:0] upc = $urandom_range(0, 1) ? lpc : apc;
      logic ut = (upc[12]) ? ((n % 6) != 5) : n[0];
      if ($urandom_range(0, 9) == 0) upc = ppc;
      cyc(logic'($urandom_range(0, 3) != 0), ppc, sel[0],
          logic'($urandom_range(0, 2) != 0), upc, ut, "R4 stream");
    end

    // R9: mid-run reset discards training
    cyc(0, 0, 0, 1, 32'h0000_0030, 1, "R9 train");
    cyc(0, 0, 0, 1, 32'h0000_0034, 0, "R9 train");
    cyc(0, 0, 0, 0, 0, 0, "R9 settle");
    do_reset();
    cyc(1, 32'h0000_0030, 0, 0, 0, 0, "R9 forward after reset");
    cyc(1, 32'h0000_0034, 1, 0, 0, 0, "R9 backward after reset");
    cyc(0, 0, 0, 0, 0, 0, "R7 final idle");
    @(negedge clk);
    check(pend_tag, pred_vld_o, pred_taken_o, exp_v, exp_t);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule